// File: doc/BRIEF.md
# Clocked NAND Bus Cycle Decoder

This block is the device-side front end of a clocked NAND flash bus that has a data strobe. On every rising clock edge it samples five things: the active-low chip select, the command strobe, the address strobe, the transfer direction and the 8-bit data bus. From these it classifies the edge as deselected, idle, command, address or other. It latches each command opcode. It gathers the address bytes that follow into a wide address register, up to a per-opcode byte count. It flags three protocol problems: an edge after an address that is not idle, an address byte that sets bits outside the implemented space, and an address cycle that is discarded.

Address bytes are dropped while the die reports busy, except after the status-enhanced opcode 78h. A configuration input tells the block that the clock period is longer than the command/address delay, and then the mandatory idle edge after an address is not required. A saturating edge counter restarts on every latched command, so that later logic can time the delay from that command edge. The data-transfer phases and the array are handled elsewhere.

Top module: `nand_cyc_decoder`

## Requirements
- R1: A rising edge with chip select low (`ce_n`=0), command strobe high, address strobe low and `dir_wr`=1 loads `dq` into `cmd_q` and pulses `cmd_valid` high for one cycle.
- R2: An address byte is taken only on an edge with `ce_n`=0, address strobe high, command strobe low and `dir_wr`=1. Byte k of the address goes to `addr_q[8k+7:8k]`, and `addr_cnt` increments by one.
- R3: A command cycle clears `addr_q` and `addr_cnt` to zero.
- R4: The expected byte count depends on the opcode in `cmd_q`: 00h/80h/85h give 5, 60h/78h give 3, 05h gives 2, 90h/EEh/EFh give 1, and every other opcode gives 0. The byte that reaches this count pulses `addr_done`. Any further address cycle is dropped, and `addr_cnt` never exceeds `ADDR_BYTES`.
- R5: While `die_ready` is 0, an address cycle is dropped (`addr_drop` pulses and `addr_cnt` is unchanged), unless `cmd_q` is 78h.
- R6: With `tck_long`=0, if the edge right after an accepted address byte has `ce_n`=0 and is not idle (idle means both strobes are low), then `idle_err` pulses.
- R7: With `tck_long`=1 when the address byte is accepted, no idle error follows that byte.
- R8: `range_err` pulses when an accepted address byte has any bit set at an overall address bit position that is at or above `ADDR_BITS` (36 by default, which means bits 7:4 of byte 4).
- R9: An edge with `ce_n`=1 clears `addr_cnt` and cancels any pending idle check.
- R10: `cad_cnt` is 0 after a command edge and then rises by one per edge, saturating at its maximum of 15 by default.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command strobe |
| ale | input | 1 | Address strobe |
| dir_wr | input | 1 | Direction, 1 = host drives bus |
| dq | input | 8 | Data bus |
| die_ready | input | 1 | Die ready (1) or busy (0) |
| tck_long | input | 1 | Clock period exceeds command/address delay |
| cmd_q | output | 8 | Current command opcode |
| cmd_valid | output | 1 | One-cycle pulse on command latch |
| addr_q | output | 8*ADDR_BYTES | Assembled address, byte 0 lowest |
| addr_cnt | output | clog2(ADDR_BYTES+1) | Address bytes collected |
| addr_done | output | 1 | Pulse when expected count is reached |
| addr_drop | output | 1 | Pulse when an address cycle is discarded |
| idle_err | output | 1 | Pulse on idle-after-address violation |
| range_err | output | 1 | Pulse on out-of-space address bit |
| cad_cnt | output | CAD_W | Edges since last command latch |

## Verification
On every cycle, the assertions check that an idle error never appears without a pending check, and that the waiver suppresses it. They also check that a busy die leaves the byte count frozen, that the done pulse matches the opcode's count, that commands and deselection clear the counter, and that the delay counter restarts. Only the bench's scenarios can show the data-side results: the exact address value that is assembled for each opcode, the full sweep of strobe combinations after an address byte with and without the waiver, the range flag at the boundary byte, and the saturation point of the delay counter.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
   typedef enum logic [2:0] {
      CYC_OFF,
      CYC_IDLE,
      CYC_CMD,
      CYC_ADDR,
      CYC_OTHER
   } cyc_e;

   localparam logic [7:0] OP_STAT_ENH = 8'h78;

   // Expected number of address bytes per opcode
   function automatic int unsigned addr_len(input logic [7:0] op);
      case (op)
         8'h00, 8'h80, 8'h85: return 5;
         8'h60, 8'h78:        return 3;
         8'h05:               return 2;
         8'h90, 8'hEE, 8'hEF: return 1;
         default:             return 0;
      endcase
   endfunction
endpackage

// File: rtl/nbd_classify.sv
module nbd_classify
   import nbd_pkg::*;
(
   input  logic ce_n,
   input  logic cle,
   input  logic ale,
   input  logic dir_wr,
   output cyc_e cyc
);
   always_comb begin
      if (ce_n)                        cyc = CYC_OFF;
      else if (!cle && !ale)           cyc = CYC_IDLE;
      else if (cle && !ale && dir_wr)  cyc = CYC_CMD;
      else if (ale && !cle && dir_wr)  cyc = CYC_ADDR;
      else                             cyc = CYC_OTHER;
   end
endmodule

// File: rtl/nbd_range_chk.sv
module nbd_range_chk #(
   parameter int ADDR_BYTES = 5,
   parameter int ADDR_BITS  = 36,
   localparam int CW = $clog2(ADDR_BYTES + 1)
) (
   input  logic [CW-1:0] idx,
   input  logic [7:0]    data,
   output logic          bad
);
   logic [7:0] mask [ADDR_BYTES];

   for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_byte
      for (genvar gb = 0; gb < 8; gb++) begin : g_bit
         assign mask[gi][gb] = ((gi * 8 + gb) >= ADDR_BITS);
      end
   end

   always_comb begin
      bad = 1'b0;
      for (int i = 0; i < ADDR_BYTES; i++) begin
         if (idx == CW'(i)) bad = |(data & mask[i]);
      end
   end
endmodule

// File: rtl/nbd_cad_timer.sv
module nbd_cad_timer #(
   parameter int CAD_W       = 4,
   parameter bit CAD_SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CAD_W-1:0] cnt
);
   logic [CAD_W-1:0] nxt;

   if (CAD_SATURATE) begin : g_sat
      assign nxt = (&cnt) ? cnt : cnt + 1'b1;
   end else begin : g_wrap
      assign nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= nxt;
   end

   AST_CAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart) |-> cnt == '0); // R10
endmodule

// File: rtl/nbd_addr_collect.sv
module nbd_addr_collect
   import nbd_pkg::*;
#(
   parameter int ADDR_BYTES = 5,
   parameter int ADDR_BITS  = 36,
   localparam int CW = $clog2(ADDR_BYTES + 1),
   localparam int AW = 8 * ADDR_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cyc_e          cyc,
   input  logic [7:0]    dq,
   input  logic          die_ready,
   input  logic          tck_long,
   output logic [7:0]    cmd_q,
   output logic          cmd_valid,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] addr_cnt,
   output logic          addr_done,
   output logic          addr_drop,
   output logic          idle_err,
   output logic          range_err
);
   logic          pend_q;
   logic [CW-1:0] exp_n;
   logic          accept;
   logic          bad_bits;

   always_comb begin
      int unsigned l;
      l = addr_len(cmd_q);
      exp_n = (l > ADDR_BYTES) ? CW'(ADDR_BYTES) : CW'(l);
   end

   assign accept = (cyc == CYC_ADDR) && (die_ready || cmd_q == OP_STAT_ENH)
                   && (addr_cnt < exp_n);

   nbd_range_chk #(.ADDR_BYTES(ADDR_BYTES), .ADDR_BITS(ADDR_BITS)) rng_i (
      .idx(addr_cnt), .data(dq), .bad(bad_bits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0; cmd_valid <= 1'b0; addr_q <= '0; addr_cnt <= '0;
         addr_done <= 1'b0; addr_drop <= 1'b0; idle_err <= 1'b0;
         range_err <= 1'b0; pend_q <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         addr_done <= 1'b0;
         addr_drop <= 1'b0;
         range_err <= 1'b0;
         pend_q    <= 1'b0;
         idle_err  <= pend_q && (cyc != CYC_IDLE) && (cyc != CYC_OFF);
         case (cyc)
            CYC_OFF: addr_cnt <= '0;
            CYC_CMD: begin
               cmd_q     <= dq;
               cmd_valid <= 1'b1;
               addr_q    <= '0;
               addr_cnt  <= '0;
            end
            CYC_ADDR: begin
               if (accept) begin
                  for (int i = 0; i < ADDR_BYTES; i++)
                     if (addr_cnt == CW'(i)) addr_q[i*8 +: 8] <= dq;
                  addr_cnt  <= addr_cnt + 1'b1;
                  addr_done <= (addr_cnt + 1'b1 == exp_n);
                  range_err <= bad_bits;
                  pend_q    <= !tck_long;
               end else begin
                  addr_drop <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   AST_IDLE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      idle_err |-> $past(pend_q)); // R6
   AST_WAIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tck_long, 2) |-> !idle_err); // R7
   AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      addr_done |-> addr_cnt == exp_n); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      addr_cnt <= CW'(ADDR_BYTES)); // R4
   AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (addr_cnt == '0 && addr_q == '0)); // R3
endmodule

// File: rtl/nand_cyc_decoder.sv
module nand_cyc_decoder
   import nbd_pkg::*;
#(
   parameter int ADDR_BYTES   = 5,
   parameter int ADDR_BITS    = 36,
   parameter int CAD_W        = 4,
   parameter bit CAD_SATURATE = 1'b1,
   localparam int CW = $clog2(ADDR_BYTES + 1),
   localparam int AW = 8 * ADDR_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             cle,
   input  logic             ale,
   input  logic             dir_wr,
   input  logic [7:0]       dq,
   input  logic             die_ready,
   input  logic             tck_long,
   output logic [7:0]       cmd_q,
   output logic             cmd_valid,
   output logic [AW-1:0]    addr_q,
   output logic [CW-1:0]    addr_cnt,
   output logic             addr_done,
   output logic             addr_drop,
   output logic             idle_err,
   output logic             range_err,
   output logic [CAD_W-1:0] cad_cnt
);
   if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_bytes
      $error("ADDR_BYTES must be 1..8");
   end
   if (ADDR_BITS <= 8 * (ADDR_BYTES - 1) || ADDR_BITS > AW) begin : g_bad_bits
      $error("ADDR_BITS must fall inside the last address byte");
   end
   if (CAD_W < 2) begin : g_bad_cad
      $error("CAD_W must be at least 2");
   end

   cyc_e cyc;

   nbd_classify cls_i (
      .ce_n(ce_n), .cle(cle), .ale(ale), .dir_wr(dir_wr), .cyc(cyc));

   nbd_addr_collect #(.ADDR_BYTES(ADDR_BYTES), .ADDR_BITS(ADDR_BITS)) col_i (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .dq(dq), .die_ready(die_ready),
      .tck_long(tck_long), .cmd_q(cmd_q), .cmd_valid(cmd_valid),
      .addr_q(addr_q), .addr_cnt(addr_cnt), .addr_done(addr_done),
      .addr_drop(addr_drop), .idle_err(idle_err), .range_err(range_err));

   nbd_cad_timer #(.CAD_W(CAD_W), .CAD_SATURATE(CAD_SATURATE)) cad_i (
      .clk(clk), .rst_n(rst_n), .restart(cyc == CYC_CMD), .cnt(cad_cnt));

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && ale && !cle && dir_wr && !die_ready && cmd_q != OP_STAT_ENH)
      |=> $stable(addr_cnt)); // R5
   AST_CE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> (addr_cnt == '0 && !idle_err)); // R9
endmodule

// File: tb/nand_cyc_decoder_tb_top.sv
`timescale 1ns/1ps
module nand_cyc_decoder_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, dir_wr = 1'b1;
   logic [7:0] dq = '0;
   logic die_ready = 1'b1, tck_long = 1'b0;
   logic [7:0] cmd_q; logic cmd_valid;
   logic [39:0] addr_q; logic [2:0] addr_cnt;
   logic addr_done, addr_drop, idle_err, range_err;
   logic [3:0] cad_cnt;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   nand_cyc_decoder dut_i (.*);

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus(bit c, bit l, bit a, bit w, logic [7:0] d);
      ce_n = c; cle = l; ale = a; dir_wr = w; dq = d;
      @(posedge clk); #1;
   endtask
   task automatic cmd(logic [7:0] op); bus(0, 1, 0, 1, op); endtask
   task automatic adr(logic [7:0] b);  bus(0, 0, 1, 1, b);  endtask
   task automatic idl();               bus(0, 0, 0, 1, 8'h00); endtask
   task automatic off();               bus(1, 0, 0, 1, 8'h00); endtask

   function automatic int elen(logic [7:0] op);
      if (op == 8'h00 || op == 8'h80 || op == 8'h85) return 5;
      if (op == 8'h60 || op == 8'h78) return 3;
      if (op == 8'h05) return 2;
      if (op == 8'h90 || op == 8'hEE || op == 8'hEF) return 1;
      return 0;
   endfunction

   function automatic logic [7:0] oob_mask(int i);
      logic [7:0] m = '0;
      for (int b = 0; b < 8; b++) m[b] = (i * 8 + b) >= 36;
      return m;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] ops [10] = '{8'h00, 8'h80, 8'h85, 8'h60, 8'h78,
                               8'h90, 8'hEE, 8'h05, 8'h30, 8'hFF};
      repeat (3) @(posedge clk); #1;
      // R11 reset state
      chk("R11 cmd_q", cmd_q, 0); chk("R11 addr_q", addr_q, 0);
      chk("R11 flags", {cmd_valid, addr_done, addr_drop, idle_err, range_err}, 0);
      chk("R11 cad_cnt", cad_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4: opcode sweep
      foreach (ops[k]) begin
         int n;
         logic [39:0] exp_a;
         n = elen(ops[k]);
         exp_a = '0;
         cmd(ops[k]);
         chk("R1 cmd_q", cmd_q, ops[k]);
         chk("R1 cmd_valid", cmd_valid, 1);
         chk("R3 addr_cnt clear", addr_cnt, 0);
         chk("R10 cad restart", cad_cnt, 0);
         for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (ops[k] ^ 8'(i * 37 + 5)) & ~oob_mask(i);
            exp_a[i*8 +: 8] = b;
            adr(b);
            chk("R2 addr_cnt", addr_cnt, i + 1);
            chk("R4 addr_done", addr_done, (i + 1 == n));
            idl();
            chk("R6 no err on idle", idle_err, 0);
         end
         chk("R2 addr_q", addr_q, exp_a);
         adr(8'h01);
         chk("R4 extra dropped", addr_drop, 1);
         chk("R4 count held", addr_cnt, n);
         idl();
         cmd(8'h30);
         chk("R3 addr_q clear", addr_q, 0);
      end

      // R6 R7 R2 R9: control sweep after an address byte
      for (int tl = 0; tl < 2; tl++) begin
         for (int c = 0; c < 16; c++) begin
            bit ce, l, a, w;
            int ecnt;
            {ce, l, a, w} = 4'(c);
            tck_long = 1'(tl);
            off(); cmd(8'h00); adr(8'h11);
            bus(ce, l, a, w, 8'h22);
            chk("R6/R7 idle_err", idle_err, (tl == 0) && !ce && (l || a));
            if (ce) ecnt = 0;
            else if (l && !a && w) ecnt = 0;
            else if (a && !l && w) ecnt = 2;
            else ecnt = 1;
            chk("R2/R9 addr_cnt", addr_cnt, ecnt);
            idl(); idl();
         end
      end
      tck_long = 1'b0;

      // R8 range flag on each byte
      for (int v = 0; v < 8; v++) begin
         cmd(8'h00);
         for (int i = 0; i < 5; i++) begin
            logic [7:0] b;
            b = 8'(1 << v);
            adr(b);
            chk("R8 range_err", range_err, (b & oob_mask(i)) != 0);
            idl();
         end
      end

      // R5 busy die
      die_ready = 1'b0;
      cmd(8'h00); adr(8'hA5);
      chk("R5 busy drop", addr_drop, 1);
      chk("R5 busy cnt", addr_cnt, 0);
      idl();
      cmd(8'h78);
      for (int i = 0; i < 3; i++) begin
         adr(8'(i + 1));
         chk("R5 78h accepted", addr_cnt, i + 1);
         chk("R5 78h done", addr_done, i == 2);
         idl();
      end
      chk("R5 78h addr", addr_q, 40'h03_02_01);
      die_ready = 1'b1;

      // R9 deselect clears pending check
      cmd(8'h00); adr(8'h10); off();
      chk("R9 no err on deselect", idle_err, 0);
      chk("R9 cnt cleared", addr_cnt, 0);
      adr(8'h20);
      chk("R9 pend cancelled", idle_err, 0);
      chk("R9 restart count", addr_cnt, 1);

      // R10 delay counter
      cmd(8'h90);
      for (int i = 1; i <= 20; i++) begin
         idl();
         chk("R10 cad_cnt", cad_cnt, (i > 15) ? 15 : i);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule